// File: doc/BRIEF.md
# Delayed-Branch Hazard and Next-PC Controller

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It owns the program counter and a valid bit for each pipeline register. Each cycle it reads the register specifiers, write enables and load flags held in the later stages, together with the branch and jump flags and the two operand values read in decode. From these it chooses the next fetch address and decides whether fetch must freeze. It also chooses where every operand should come from: the register file, the execute/memory result or the memory/writeback result.

Conditional branches compare two registers for equality or inequality and are resolved in decode. The instruction in fetch at that moment is the delay slot, and it always runs. No fetched instruction is ever discarded, so the block has no flush output. Jumps follow the same rule. When a load feeds the instruction right behind it, a one-cycle interlock applies. A branch whose operands are still being produced waits until a forwarding path can supply them.

Top module: `dslot_hazard_ctrl`

## Requirements
- R1: Synchronous active-high reset puts the PC at 0 and clears every pipeline valid bit. In the first cycle after reset no stall is raised and no forward is selected, whatever the stage inputs show.
- R2: With no stall and no redirect, the PC advances by 4 on every clock.
- R3: When a load in execute writes a register that the decode instruction uses as a source (flagged by id_use_rs / id_use_rt), pc_hold, ifid_hold and idex_bubble rise together for that cycle. Register 0, an unused source, or a load that does not write never stalls.
- R4: Execute-operand select codes are 0 for the register file, 1 for execute/memory and 2 for memory/writeback. The execute/memory stage wins when both match. A producer with write enable low or destination 0 is never selected. A dependent ALU instruction needs no stall.
- R5: A branch in decode with id_bne=0 is taken when its compared operands are equal, and with id_bne=1 when they differ. The target is the current PC (the delay-slot address) plus the sign-extended 16-bit offset shifted left by two. A branch that is not taken gives PC+4.
- R6: In a redirect cycle neither ifid_hold nor idex_bubble is raised, so the delay-slot instruction enters decode and runs.
- R7: A jump in decode sets the next PC to the upper 4 bits of the current PC, then the 26-bit jump field, then two zero bits.
- R8: A branch whose source is written by an ALU instruction in execute stalls one cycle. It then compares using the execute/memory result, with decode select code 1. A load sitting in execute/memory is never selected for the decode operands.
- R9: A branch whose source is written by a load stalls for two cycles while the load is in execute and then in memory.
- R10: A decode operand written by the instruction in writeback is taken from the writeback result, with decode select code 2.
- R11: While a stall is raised, the next PC equals the current PC and any branch or jump in decode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | 5 | First source register in decode |
| id_rt | input | 5 | Second source register in decode |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_bne | input | 1 | Branch condition is inequality |
| id_jump | input | 1 | Decode instruction is a jump |
| id_offset | input | 16 | Branch word offset |
| id_jtarget | input | 26 | Jump word field |
| id_rs_val | input | 32 | Register-file value of id_rs |
| id_rt_val | input | 32 | Register-file value of id_rt |
| ex_rs | input | 5 | First source in execute |
| ex_rt | input | 5 | Second source in execute |
| ex_dst | input | 5 | Destination in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination in memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_result | input | 32 | Execute/memory register result |
| wb_dst | input | 5 | Destination in writeback |
| wb_wen | input | 1 | Writeback instruction writes |
| wb_result | input | 32 | Memory/writeback result |
| pc | output | 32 | Current fetch address |
| pc_next | output | 32 | Fetch address for the next cycle |
| pc_hold | output | 1 | Freeze the PC |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| fwd_ex_a | output | 2 | Source select for execute operand A |
| fwd_ex_b | output | 2 | Source select for execute operand B |
| fwd_id_a | output | 2 | Source select for decode compare operand A |
| fwd_id_b | output | 2 | Source select for decode compare operand B |

## Verification
The bound checker watches the properties that hold in every cycle: the PC reset value, sequential increments, the PC freezing under a stall, the bubble always coming with both holds, legal select codes that never point at register 0, and a load in memory never being forwarded into decode. Other behaviour only shows up in a planned sequence of pipeline contents, and only the bench's scenarios can show it. This covers select priority, branch targets in both senses, the jump address, the delay slot being kept, and the one- and two-cycle waits of a branch behind an ALU instruction or a load, followed by the right forwarding source.

// File: rtl/dsh_pkg.sv
package dsh_pkg;

    localparam int RIDX_W = 5;

    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } src_e;

    typedef struct packed {
        logic  valid;
        logic  wen;
        logic  load;
        ridx_t dst;
    } prod_t;

    function automatic logic prod_writes(prod_t p, ridx_t r);
        return p.valid && p.wen && (p.dst != '0) && (p.dst == r);
    endfunction

    function automatic src_e pick_src(ridx_t r, prod_t near, prod_t far, logic near_load_ok);
        if (prod_writes(near, r) && (near_load_ok || !near.load))
            return SRC_EXMEM;
        if (prod_writes(far, r))
            return SRC_MEMWB;
        return SRC_RF;
    endfunction

endpackage

// File: rtl/dsh_src_select.sv
module dsh_src_select
    import dsh_pkg::*;
#(
    parameter int NOPS         = 2,
    parameter bit NEAR_LOAD_OK = 1'b1
) (
    input  logic                     en,
    input  logic [NOPS*RIDX_W-1:0]   srcs,
    input  prod_t                    near,
    input  prod_t                    far,
    output logic [2*NOPS-1:0]        sel
);

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        src_e pick;
        always_comb begin
            pick = en ? pick_src(srcs[i*RIDX_W +: RIDX_W], near, far, NEAR_LOAD_OK) : SRC_RF;
        end
        assign sel[2*i +: 2] = pick;
    end

endmodule

// File: rtl/dsh_interlock.sv
module dsh_interlock
    import dsh_pkg::*;
(
    input  logic  id_valid,
    input  ridx_t id_rs,
    input  ridx_t id_rt,
    input  logic  use_rs,
    input  logic  use_rt,
    input  logic  is_branch,
    input  prod_t ex_p,
    input  prod_t mem_p,
    output logic  stall
);

    logic ex_rs_hit, ex_rt_hit, mem_rs_hit, mem_rt_hit;
    logic load_use, br_on_ex, br_on_mem_load;

    always_comb begin
        ex_rs_hit      = prod_writes(ex_p, id_rs);
        ex_rt_hit      = prod_writes(ex_p, id_rt);
        mem_rs_hit     = prod_writes(mem_p, id_rs);
        mem_rt_hit     = prod_writes(mem_p, id_rt);
        load_use       = ex_p.load && ((use_rs && ex_rs_hit) || (use_rt && ex_rt_hit));
        br_on_ex       = is_branch && (ex_rs_hit || ex_rt_hit);
        br_on_mem_load = is_branch && mem_p.load && (mem_rs_hit || mem_rt_hit);
        stall          = id_valid && (load_use || br_on_ex || br_on_mem_load);
    end

endmodule

// File: rtl/dsh_pc_gen.sv
module dsh_pc_gen #(
    parameter int XLEN = 32,
    parameter int OFFW = 16,
    parameter int JTW  = 26
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            take_br,
    input  logic            take_j,
    input  logic [OFFW-1:0] offset,
    input  logic [JTW-1:0]  jfield,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_next
);

    localparam int SEXT_W = XLEN - OFFW - 2;
    localparam int JHI    = XLEN - JTW - 2;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] br_addr, j_addr;

    always_comb begin
        br_addr = pc + {{SEXT_W{offset[OFFW-1]}}, offset, 2'b00};
        j_addr  = {pc[XLEN-1 -: JHI], jfield, 2'b00};
        if (hold)
            pc_next = pc;
        else if (take_j)
            pc_next = j_addr;
        else if (take_br)
            pc_next = br_addr;
        else
            pc_next = pc + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else
            pc <= pc_next;
    end

endmodule

// File: rtl/dslot_hazard_ctrl.sv
module dslot_hazard_ctrl
    import dsh_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 16,
    parameter int JTW  = 26
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      id_rs,
    input  logic [4:0]      id_rt,
    input  logic            id_use_rs,
    input  logic            id_use_rt,
    input  logic            id_branch,
    input  logic            id_bne,
    input  logic            id_jump,
    input  logic [OFFW-1:0] id_offset,
    input  logic [JTW-1:0]  id_jtarget,
    input  logic [XLEN-1:0] id_rs_val,
    input  logic [XLEN-1:0] id_rt_val,
    input  logic [4:0]      ex_rs,
    input  logic [4:0]      ex_rt,
    input  logic [4:0]      ex_dst,
    input  logic            ex_wen,
    input  logic            ex_load,
    input  logic [4:0]      mem_dst,
    input  logic            mem_wen,
    input  logic            mem_load,
    input  logic [XLEN-1:0] mem_result,
    input  logic [4:0]      wb_dst,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_result,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_next,
    output logic            pc_hold,
    output logic            ifid_hold,
    output logic            idex_bubble,
    output logic [1:0]      fwd_ex_a,
    output logic [1:0]      fwd_ex_b,
    output logic [1:0]      fwd_id_a,
    output logic [1:0]      fwd_id_b
);

    logic ifid_v, idex_v, exmem_v, memwb_v;
    logic stall;
    prod_t ex_p, mem_p, wb_p;
    logic [XLEN-1:0] cmp_a, cmp_b;
    logic id_live, take_br, take_j;

    // valid chain: a stall holds decode and sends a bubble onward
    always_ff @(posedge clk) begin
        if (rst) begin
            ifid_v  <= 1'b0;
            idex_v  <= 1'b0;
            exmem_v <= 1'b0;
            memwb_v <= 1'b0;
        end else begin
            if (!stall)
                ifid_v <= 1'b1;
            idex_v  <= ifid_v && !stall;
            exmem_v <= idex_v;
            memwb_v <= exmem_v;
        end
    end

    always_comb begin
        ex_p  = '{valid: idex_v,  wen: ex_wen,  load: ex_load,  dst: ex_dst};
        mem_p = '{valid: exmem_v, wen: mem_wen, load: mem_load, dst: mem_dst};
        wb_p  = '{valid: memwb_v, wen: wb_wen,  load: 1'b0,     dst: wb_dst};
    end

    dsh_interlock u_lock (
        .id_valid  (ifid_v),
        .id_rs     (id_rs),
        .id_rt     (id_rt),
        .use_rs    (id_use_rs),
        .use_rt    (id_use_rt),
        .is_branch (id_branch),
        .ex_p      (ex_p),
        .mem_p     (mem_p),
        .stall     (stall)
    );

    dsh_src_select #(.NOPS(2), .NEAR_LOAD_OK(1'b1)) u_ex_sel (
        .en   (idex_v),
        .srcs ({ex_rt, ex_rs}),
        .near (mem_p),
        .far  (wb_p),
        .sel  ({fwd_ex_b, fwd_ex_a})
    );

    dsh_src_select #(.NOPS(2), .NEAR_LOAD_OK(1'b0)) u_id_sel (
        .en   (ifid_v),
        .srcs ({id_rt, id_rs}),
        .near (mem_p),
        .far  (wb_p),
        .sel  ({fwd_id_b, fwd_id_a})
    );

    always_comb begin
        unique case (fwd_id_a)
            SRC_EXMEM: cmp_a = mem_result;
            SRC_MEMWB: cmp_a = wb_result;
            default:   cmp_a = id_rs_val;
        endcase
        unique case (fwd_id_b)
            SRC_EXMEM: cmp_b = mem_result;
            SRC_MEMWB: cmp_b = wb_result;
            default:   cmp_b = id_rt_val;
        endcase
        id_live = ifid_v && !stall;
        take_br = id_live && id_branch && ((cmp_a == cmp_b) ^ id_bne);
        take_j  = id_live && id_jump;
    end

    dsh_pc_gen #(.XLEN(XLEN), .OFFW(OFFW), .JTW(JTW)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .hold    (stall),
        .take_br (take_br),
        .take_j  (take_j),
        .offset  (id_offset),
        .jfield  (id_jtarget),
        .pc      (pc),
        .pc_next (pc_next)
    );

    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;

endmodule

// File: rtl/dsh_checker.sv
module dsh_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic            pc_hold,
    input logic            ifid_hold,
    input logic            idex_bubble,
    input logic            id_branch,
    input logic            id_jump,
    input logic [4:0]      ex_rs,
    input logic [4:0]      ex_rt,
    input logic            mem_load,
    input logic [1:0]      fwd_ex_a,
    input logic [1:0]      fwd_ex_b,
    input logic [1:0]      fwd_id_a,
    input logic [1:0]      fwd_id_b
);

    assert_reset_pc_R1: assert property (@(posedge clk) rst |=> (pc == '0));

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !pc_hold);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!pc_hold && !id_branch && !id_jump) |=> (pc == $past(pc) + XLEN'(4)));

    assert_bubble_with_holds_R3: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> (pc_hold && ifid_hold));

    assert_stall_freezes_pc_R11: assert property (@(posedge clk) disable iff (rst)
        pc_hold |=> (pc == $past(pc)));

    assert_fwd_a_not_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (fwd_ex_a != 2'd0) |-> (ex_rs != 5'd0));

    assert_fwd_b_not_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (fwd_ex_b != 2'd0) |-> (ex_rt != 5'd0));

    assert_fwd_codes_legal_R4: assert property (@(posedge clk) disable iff (rst)
        (fwd_ex_a != 2'd3) && (fwd_ex_b != 2'd3) && (fwd_id_a != 2'd3) && (fwd_id_b != 2'd3));

    assert_id_no_load_fwd_R8: assert property (@(posedge clk) disable iff (rst)
        ((fwd_id_a == 2'd1) || (fwd_id_b == 2'd1)) |-> !mem_load);

endmodule

bind dslot_hazard_ctrl dsh_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc          (pc),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .id_branch   (id_branch),
    .id_jump     (id_jump),
    .ex_rs       (ex_rs),
    .ex_rt       (ex_rt),
    .mem_load    (mem_load),
    .fwd_ex_a    (fwd_ex_a),
    .fwd_ex_b    (fwd_ex_b),
    .fwd_id_a    (fwd_id_a),
    .fwd_id_b    (fwd_id_b)
);

// File: tb/dslot_hazard_ctrl_test.sv
module dslot_hazard_ctrl_test;

    logic clk = 1'b0;
    logic rst;
    logic [4:0]  id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
    logic        id_use_rs, id_use_rt, id_branch, id_bne, id_jump;
    logic [15:0] id_offset;
    logic [25:0] id_jtarget;
    logic [31:0] id_rs_val, id_rt_val, mem_result, wb_result;
    logic        ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    logic [31:0] pc, pc_next;
    logic        pc_hold, ifid_hold, idex_bubble;
    logic [1:0]  fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dslot_hazard_ctrl uut (
        .clk(clk), .rst(rst),
        .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
        .id_branch(id_branch), .id_bne(id_bne), .id_jump(id_jump),
        .id_offset(id_offset), .id_jtarget(id_jtarget),
        .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load), .mem_result(mem_result),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_result(wb_result),
        .pc(pc), .pc_next(pc_next), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .idex_bubble(idex_bubble), .fwd_ex_a(fwd_ex_a), .fwd_ex_b(fwd_ex_b),
        .fwd_id_a(fwd_id_a), .fwd_id_b(fwd_id_b)
    );

    typedef struct packed {
        logic [4:0] rs, rt;
        logic       urs, urt;
        logic [4:0] xrs, xrt, xd;
        logic       xw, xl;
        logic [4:0] md;
        logic       mw, ml;
        logic [4:0] wd;
        logic       ww;
        logic       stall;
        logic [1:0] fa, fb, ca, cb;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // no dependency: R2
        '{5'd1, 5'd2, 1'b1, 1'b1, 5'd3, 5'd4, 5'd9, 1'b1, 1'b0, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        // both forward paths: R4
        '{5'd1, 5'd2, 1'b1, 1'b1, 5'd10, 5'd11, 5'd9, 1'b1, 1'b0, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 2'd1, 2'd2, 2'd0, 2'd0},
        // priority of execute/memory: R4
        '{5'd1, 5'd2, 1'b1, 1'b1, 5'd7, 5'd7, 5'd9, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'd1, 2'd1, 2'd0, 2'd0},
        // register zero: R3 R4
        '{5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        // near producer not writing: R4
        '{5'd1, 5'd2, 1'b1, 1'b1, 5'd7, 5'd3, 5'd9, 1'b1, 1'b0, 5'd7, 1'b0, 1'b0, 5'd7, 1'b1, 1'b0, 2'd2, 2'd0, 2'd0, 2'd0},
        // load-use on rs: R3
        '{5'd6, 5'd2, 1'b1, 1'b1, 5'd3, 5'd4, 5'd6, 1'b1, 1'b1, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0},
        // load matches unused rt: R3
        '{5'd1, 5'd6, 1'b1, 1'b0, 5'd3, 5'd4, 5'd6, 1'b1, 1'b1, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        // load-use on rt: R3
        '{5'd1, 5'd6, 1'b1, 1'b1, 5'd3, 5'd4, 5'd6, 1'b1, 1'b1, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0},
        // ALU producer, no stall: R4
        '{5'd6, 5'd6, 1'b1, 1'b1, 5'd3, 5'd4, 5'd6, 1'b1, 1'b0, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        // decode forwarding: R10 R8
        '{5'd10, 5'd11, 1'b1, 1'b1, 5'd3, 5'd4, 5'd9, 1'b1, 1'b0, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 2'd0, 2'd0, 2'd1, 2'd2},
        // load in memory never forwarded to decode: R8
        '{5'd10, 5'd2, 1'b1, 1'b1, 5'd3, 5'd4, 5'd9, 1'b1, 1'b0, 5'd10, 1'b1, 1'b1, 5'd11, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
        // load flag without write: R3
        '{5'd6, 5'd2, 1'b1, 1'b1, 5'd3, 5'd4, 5'd6, 1'b0, 1'b1, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic neutral();
        id_rs = '0; id_rt = '0; id_use_rs = 1'b0; id_use_rt = 1'b0;
        id_branch = 1'b0; id_bne = 1'b0; id_jump = 1'b0;
        id_offset = '0; id_jtarget = '0; id_rs_val = '0; id_rt_val = '0;
        ex_rs = '0; ex_rt = '0; ex_dst = '0; ex_wen = 1'b0; ex_load = 1'b0;
        mem_dst = '0; mem_wen = 1'b0; mem_load = 1'b0; mem_result = '0;
        wb_dst = '0; wb_wen = 1'b0; wb_result = '0;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            neutral();
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] p;
        neutral();
        rst = 1'b1;
        // hazard-looking inputs during reset: R1
        id_rs = 5'd6; id_use_rs = 1'b1; ex_dst = 5'd6; ex_wen = 1'b1; ex_load = 1'b1;
        ex_rs = 5'd7; mem_dst = 5'd7; mem_wen = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 pc in reset", pc, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1 pc after reset", pc, 32'h0);
        chk("R1 no stall after reset", {31'b0, pc_hold}, 32'h0);
        chk("R1 no forward after reset", {30'b0, fwd_ex_a}, 32'h0);
        @(negedge clk);
        #2;
        chk("R2 first step", pc, 32'h4);

        // sequential fetch: R2
        settle(1);
        for (int k = 0; k < 3; k++) begin
            #2;
            p = pc;
            @(negedge clk);
            #2;
            chk("R2 pc plus four", pc, p + 32'd4);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            settle(4);
            id_rs = VECS[v].rs; id_rt = VECS[v].rt;
            id_use_rs = VECS[v].urs; id_use_rt = VECS[v].urt;
            ex_rs = VECS[v].xrs; ex_rt = VECS[v].xrt; ex_dst = VECS[v].xd;
            ex_wen = VECS[v].xw; ex_load = VECS[v].xl;
            mem_dst = VECS[v].md; mem_wen = VECS[v].mw; mem_load = VECS[v].ml;
            wb_dst = VECS[v].wd; wb_wen = VECS[v].ww;
            #2;
            chk($sformatf("R3 vec%0d stall", v), {29'b0, pc_hold, ifid_hold, idex_bubble},
                {29'b0, {3{VECS[v].stall}}});
            chk($sformatf("R4 vec%0d fwd_ex_a", v), {30'b0, fwd_ex_a}, {30'b0, VECS[v].fa});
            chk($sformatf("R4 vec%0d fwd_ex_b", v), {30'b0, fwd_ex_b}, {30'b0, VECS[v].fb});
            chk($sformatf("R10 vec%0d fwd_id_a", v), {30'b0, fwd_id_a}, {30'b0, VECS[v].ca});
            chk($sformatf("R10 vec%0d fwd_id_b", v), {30'b0, fwd_id_b}, {30'b0, VECS[v].cb});
        end

        // beq taken, delay slot kept: R5 R6
        settle(4);
        id_rs = 5'd1; id_rt = 5'd2; id_branch = 1'b1; id_offset = 16'd3;
        id_rs_val = 32'd5; id_rt_val = 32'd5;
        #2;
        p = pc;
        chk("R5 beq taken target", pc_next, p + 32'd12);
        chk("R6 no hold on redirect", {30'b0, ifid_hold, idex_bubble}, 32'h0);
        @(negedge clk);
        neutral();
        #2;
        chk("R5 pc at target", pc, p + 32'd12);

        // beq not taken: R5
        settle(1);
        id_rs = 5'd1; id_rt = 5'd2; id_branch = 1'b1; id_offset = 16'd3;
        id_rs_val = 32'd5; id_rt_val = 32'd6;
        #2;
        chk("R5 beq not taken", pc_next, pc + 32'd4);

        // bne taken with negative offset: R5
        settle(1);
        id_rs = 5'd1; id_rt = 5'd2; id_branch = 1'b1; id_bne = 1'b1; id_offset = 16'hFFFE;
        id_rs_val = 32'd1; id_rt_val = 32'd2;
        #2;
        chk("R5 bne taken backward", pc_next, pc - 32'd8);

        // jump: R7
        settle(1);
        id_jump = 1'b1; id_jtarget = 26'h0123456;
        #2;
        chk("R7 jump target", pc_next, {pc[31:28], 26'h0123456, 2'b00});

        // branch behind ALU producer: R8 R11
        settle(4);
        id_rs = 5'd5; id_rt = 5'd6; id_branch = 1'b1; id_offset = 16'd4;
        ex_dst = 5'd5; ex_wen = 1'b1;
        #2;
        p = pc;
        chk("R8 branch waits on ALU", {31'b0, pc_hold}, 32'h1);
        chk("R11 pc_next frozen", pc_next, p);
        @(negedge clk);
        ex_dst = '0; ex_wen = 1'b0;
        mem_dst = 5'd5; mem_wen = 1'b1; mem_result = 32'd77;
        id_rs_val = 32'd0; id_rt_val = 32'd77;
        #2;
        chk("R11 pc held", pc, p);
        chk("R8 stall released", {31'b0, pc_hold}, 32'h0);
        chk("R8 decode fwd from exmem", {30'b0, fwd_id_a}, 32'd1);
        chk("R8 compare with forwarded value", pc_next, p + 32'd16);

        // branch behind load: R9 R10
        settle(4);
        id_rs = 5'd5; id_rt = 5'd6; id_branch = 1'b1; id_offset = 16'd2;
        ex_dst = 5'd5; ex_wen = 1'b1; ex_load = 1'b1;
        #2;
        p = pc;
        chk("R9 stall with load in execute", {31'b0, pc_hold}, 32'h1);
        @(negedge clk);
        ex_dst = '0; ex_wen = 1'b0; ex_load = 1'b0;
        mem_dst = 5'd5; mem_wen = 1'b1; mem_load = 1'b1;
        #2;
        chk("R9 stall with load in memory", {31'b0, pc_hold}, 32'h1);
        chk("R11 pc held across load", pc, p);
        @(negedge clk);
        mem_dst = '0; mem_wen = 1'b0; mem_load = 1'b0;
        wb_dst = 5'd5; wb_wen = 1'b1; wb_result = 32'd9;
        id_rs_val = 32'd1; id_rt_val = 32'd9;
        #2;
        chk("R9 released after two cycles", {31'b0, pc_hold}, 32'h0);
        chk("R10 decode fwd from writeback", {30'b0, fwd_id_a}, 32'd2);
        chk("R10 branch taken on wb value", pc_next, p + 32'd8);

        settle(1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule